// File: doc/BRIEF.md
# Dependency-Aware Issue Interlock

This block is the issue gate of a single-issue, in-order pipeline. Each cycle it may be shown one decoded instruction: an operation class, an optional destination register and up to two optional source registers. It lets the instruction go (`issue_valid`) unless a source it reads is still being produced by an earlier instruction. In that case it raises `stall`, and the instruction is held upstream until the operand is usable. Instructions that read nothing pending are not held back, even while a long divide or load is still in flight.

Every architectural register has a small countdown of the cycles left before its newest result can be used. When a producer issues, its destination countdown is loaded with the extra latency of its class. A taken branch costs one empty delay-slot cycle after it issues. A free-running cycle counter lets the cycles spent per loop pass be read at the ports.

Top module: `issue_interlock`

## Requirements
- R1: While reset is held, and after it is released, `issue_valid` and `stall` are 0 with `in_valid` low and `cycle_count` is 0. Reset clears every pending result, so a consumer presented after reset issues in its first cycle.
- R2: `op_class` encodes the extra latency N: 0 add-immediate N=0, 1 load N=4, 2 divide N=12, 3 multiply N=5, 4 floating add N=1, 5 integer subtract N=1, 6 store N=1, 7 branch N=0. A consumer presented right after its producer issues N+1 cycles after that producer.
- R3: `stall` is 1 in a cycle where a valid instruction reads (use bit 1) a register whose result is pending, or where a delay slot is being spent, and 0 otherwise. `issue_valid` equals `in_valid` and not `stall`, so at most one instruction issues per cycle.
- R4: An instruction that reads no pending register issues in the cycle it is presented, even while a longer-latency result is still outstanding.
- R5: Register 0 never blocks issue, and neither does a source whose use bit is 0. A producer whose destination is register 0 leaves nothing pending.
- R6: An issuing producer updates its destination countdown in the same cycle. A later producer of the same register replaces the earlier countdown, so its consumer waits only for the newest producer.
- R7: After a branch (class 7) issues with `br_taken` = 1, the next cycle is a delay slot: `stall` = 1 and `issue_valid` = 0. A branch with `br_taken` = 0 leaves no slot.
- R8: `cycle_count` rises by exactly 1 every cycle after reset and wraps at its width.
- R9: For the eleven-instruction loop body used by the bench (load, divide, multiply, load, two floating adds, two add-immediates, store, subtract, taken branch), one pass takes 26 cycles from one issue of the first load to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A decoded instruction is presented |
| op_class | input | 3 | Operation class (encoding in R2) |
| dst_reg | input | IDX_W (5) | Destination register |
| dst_use | input | 1 | Instruction writes `dst_reg` |
| src_a | input | IDX_W (5) | First source register |
| src_a_use | input | 1 | Instruction reads `src_a` |
| src_b | input | IDX_W (5) | Second source register |
| src_b_use | input | 1 | Instruction reads `src_b` |
| br_taken | input | 1 | Branch outcome, used with class 7 |
| issue_valid | output | 1 | The presented instruction issues this cycle |
| stall | output | 1 | Issue is held back this cycle |
| cycle_count | output | CYC_W (16) | Free-running cycle counter |

## Verification
`stall` and `issue_valid` follow the presented instruction in the same cycle. A countdown loaded at an issue edge first blocks in the next cycle. The delay slot falls in the cycle right after the issue edge of the taken branch, and `cycle_count` moves once per rising edge. The bench drives inputs on the falling edge, samples one nanosecond later, and records the `cycle_count` value seen in the cycle an instruction issues. It then compares differences of these issue cycles against latencies worked out from the requirements. The instruction is held until the rising edge that completes its issue, so that consecutive instructions go back to back.

// File: rtl/iil_pkg.sv
package iil_pkg;

  typedef enum logic [2:0] {
    OPC_ALUI   = 3'd0,
    OPC_LOAD   = 3'd1,
    OPC_FDIV   = 3'd2,
    OPC_FMUL   = 3'd3,
    OPC_FADD   = 3'd4,
    OPC_ISUB   = 3'd5,
    OPC_STORE  = 3'd6,
    OPC_BRANCH = 3'd7
  } opc_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/iil_lat_decode.sv
module iil_lat_decode
  import iil_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int LAT_ALUI   = 0,
  parameter int LAT_LOAD   = 4,
  parameter int LAT_FDIV   = 12,
  parameter int LAT_FMUL   = 5,
  parameter int LAT_FADD   = 1,
  parameter int LAT_ISUB   = 1,
  parameter int LAT_STORE  = 1,
  parameter int LAT_BRANCH = 0
) (
  input  opc_e             op,
  output logic [CNT_W-1:0] lat
);

  always_comb begin
    unique case (op)
      OPC_ALUI:   lat = CNT_W'(LAT_ALUI);
      OPC_LOAD:   lat = CNT_W'(LAT_LOAD);
      OPC_FDIV:   lat = CNT_W'(LAT_FDIV);
      OPC_FMUL:   lat = CNT_W'(LAT_FMUL);
      OPC_FADD:   lat = CNT_W'(LAT_FADD);
      OPC_ISUB:   lat = CNT_W'(LAT_ISUB);
      OPC_STORE:  lat = CNT_W'(LAT_STORE);
      OPC_BRANCH: lat = CNT_W'(LAT_BRANCH);
      default:    lat = '0;
    endcase
  end

endmodule

// File: rtl/iil_scoreboard.sv
module iil_scoreboard #(
  parameter int NREG  = 32,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [CNT_W-1:0] ld_val,
  output logic [NREG-1:0]  pending
);

  // register 0 is hard-wired ready
  assign pending[0] = 1'b0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             hit;
    logic             cnt_ce;

    assign hit = ld_en && (ld_idx == IDX_W'(r));

    always_comb begin
      cnt_ce = hit || (cnt_q != '0);
      cnt_d  = cnt_q;
      if (hit) begin
        cnt_d = ld_val;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_ce) begin
        cnt_q <= cnt_d;
      end
    end

    assign pending[r] = (cnt_q != '0);
  end

endmodule

// File: rtl/iil_issue_ctl.sv
module iil_issue_ctl #(
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] src_a,
  input  logic             src_a_use,
  input  logic [IDX_W-1:0] src_b,
  input  logic             src_b_use,
  input  logic             is_branch,
  input  logic             br_taken,
  input  logic [NREG-1:0]  pending,
  output logic             stall,
  output logic             issue_valid
);

  logic hazard;
  logic slot_q;
  logic slot_d;

  always_comb begin
    hazard      = (src_a_use && pending[src_a]) || (src_b_use && pending[src_b]);
    stall       = slot_q || (in_valid && hazard);
    issue_valid = in_valid && rst_n && !stall;
    slot_d      = issue_valid && is_branch && br_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/iil_cycle_ctr.sv
module iil_cycle_ctr #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CYC_W-1:0] count
);

  logic [CYC_W-1:0] count_d;

  always_comb begin
    count_d = count + CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import iil_pkg::*;
#(
  parameter int NREG       = 32,
  parameter int CYC_W      = 16,
  parameter int LAT_ALUI   = 0,
  parameter int LAT_LOAD   = 4,
  parameter int LAT_FDIV   = 12,
  parameter int LAT_FMUL   = 5,
  parameter int LAT_FADD   = 1,
  parameter int LAT_ISUB   = 1,
  parameter int LAT_STORE  = 1,
  parameter int LAT_BRANCH = 0,
  localparam int IDX_W   = $clog2(NREG),
  localparam int MAX_LAT = imax(imax(imax(LAT_ALUI, LAT_LOAD), imax(LAT_FDIV, LAT_FMUL)),
                                imax(imax(LAT_FADD, LAT_ISUB), imax(LAT_STORE, LAT_BRANCH))),
  localparam int CNT_W   = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op_class,
  input  logic [IDX_W-1:0] dst_reg,
  input  logic             dst_use,
  input  logic [IDX_W-1:0] src_a,
  input  logic             src_a_use,
  input  logic [IDX_W-1:0] src_b,
  input  logic             src_b_use,
  input  logic             br_taken,
  output logic             issue_valid,
  output logic             stall,
  output logic [CYC_W-1:0] cycle_count
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  opc_e             op;
  logic [CNT_W-1:0] lat;
  logic [NREG-1:0]  pending;
  logic             ld_en;
  logic             is_branch;

  assign op        = opc_e'(op_class);
  assign is_branch = (op == OPC_BRANCH);
  assign ld_en     = issue_valid && dst_use && (dst_reg != '0);

  iil_lat_decode #(
    .CNT_W     (CNT_W),
    .LAT_ALUI  (LAT_ALUI),
    .LAT_LOAD  (LAT_LOAD),
    .LAT_FDIV  (LAT_FDIV),
    .LAT_FMUL  (LAT_FMUL),
    .LAT_FADD  (LAT_FADD),
    .LAT_ISUB  (LAT_ISUB),
    .LAT_STORE (LAT_STORE),
    .LAT_BRANCH(LAT_BRANCH)
  ) u_lat (
    .op (op),
    .lat(lat)
  );

  iil_scoreboard #(
    .NREG (NREG),
    .CNT_W(CNT_W)
  ) u_sb (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ld_en  (ld_en),
    .ld_idx (dst_reg),
    .ld_val (lat),
    .pending(pending)
  );

  iil_issue_ctl #(
    .NREG(NREG)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .in_valid   (in_valid),
    .src_a      (src_a),
    .src_a_use  (src_a_use),
    .src_b      (src_b),
    .src_b_use  (src_b_use),
    .is_branch  (is_branch),
    .br_taken   (br_taken),
    .pending    (pending),
    .stall      (stall),
    .issue_valid(issue_valid)
  );

  iil_cycle_ctr #(
    .CYC_W(CYC_W)
  ) u_ctr (
    .clk  (clk),
    .rst_n(rst_q_n),
    .count(cycle_count)
  );

endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk #(
  parameter int IDX_W = 5,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       op_class,
  input logic [IDX_W-1:0] dst_reg,
  input logic             dst_use,
  input logic [IDX_W-1:0] src_a,
  input logic             src_a_use,
  input logic [IDX_W-1:0] src_b,
  input logic             src_b_use,
  input logic             br_taken,
  input logic             issue_valid,
  input logic             stall,
  input logic [CYC_W-1:0] cycle_count
);

  logic taken_br;
  logic a_free;
  logic b_free;

  assign taken_br = issue_valid && (op_class == 3'd7) && br_taken;
  assign a_free   = !src_a_use || (src_a == '0);
  assign b_free   = !src_b_use || (src_b == '0);

  // R7: a taken branch leaves one empty slot behind it
  p_taken_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    taken_br |=> (stall && !issue_valid));

  // R8: counter steps by one every cycle
  p_cycle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cycle_count == $past(cycle_count) + CYC_W'(1)));

  // R5: reading only register 0 or unused fields never waits
  p_free_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_free && b_free && !$past(taken_br)) |-> issue_valid);

  // R2: a load's immediate consumer is held
  p_load_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_a_use && (src_a != '0) && (src_a == $past(dst_reg)) &&
     $past(issue_valid && dst_use && (op_class == 3'd1))) |-> stall);

  // R3: nothing presented and no slot pending means no stall
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !$past(taken_br)) |-> (!stall && !issue_valid));

endmodule

bind issue_interlock issue_interlock_chk #(
  .IDX_W(IDX_W),
  .CYC_W(CYC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .in_valid   (in_valid),
  .op_class   (op_class),
  .dst_reg    (dst_reg),
  .dst_use    (dst_use),
  .src_a      (src_a),
  .src_a_use  (src_a_use),
  .src_b      (src_b),
  .src_b_use  (src_b_use),
  .br_taken   (br_taken),
  .issue_valid(issue_valid),
  .stall      (stall),
  .cycle_count(cycle_count)
);

// File: tb/issue_interlock_bench.sv
module issue_interlock_bench;

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] dst;
    logic       du;
    logic [4:0] sa;
    logic       sau;
    logic [4:0] sb;
    logic       sbu;
    logic       tk;
    logic [7:0] exp_t;
  } vec_t;

  // loop body, two passes; exp_t = issue cycle relative to the first load
  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 5'd12, 1'b1, 5'd1,  1'b1, 5'd0,  1'b0, 1'b0, 8'd0},
    '{3'd2, 5'd18, 1'b1, 5'd12, 1'b1, 5'd10, 1'b1, 1'b0, 8'd5},
    '{3'd3, 5'd12, 1'b1, 5'd16, 1'b1, 5'd12, 1'b1, 1'b0, 8'd6},
    '{3'd1, 5'd14, 1'b1, 5'd2,  1'b1, 5'd0,  1'b0, 1'b0, 8'd7},
    '{3'd4, 5'd14, 1'b1, 5'd10, 1'b1, 5'd14, 1'b1, 1'b0, 8'd12},
    '{3'd4, 5'd20, 1'b1, 5'd18, 1'b1, 5'd12, 1'b1, 1'b0, 8'd18},
    '{3'd0, 5'd1,  1'b1, 5'd1,  1'b1, 5'd0,  1'b0, 1'b0, 8'd19},
    '{3'd0, 5'd2,  1'b1, 5'd2,  1'b1, 5'd0,  1'b0, 1'b0, 8'd20},
    '{3'd6, 5'd0,  1'b0, 5'd14, 1'b1, 5'd2,  1'b1, 1'b0, 8'd21},
    '{3'd5, 5'd5,  1'b1, 5'd4,  1'b1, 5'd1,  1'b1, 1'b0, 8'd22},
    '{3'd7, 5'd0,  1'b0, 5'd5,  1'b1, 5'd0,  1'b0, 1'b1, 8'd24},
    '{3'd1, 5'd12, 1'b1, 5'd1,  1'b1, 5'd0,  1'b0, 1'b0, 8'd26},
    '{3'd2, 5'd18, 1'b1, 5'd12, 1'b1, 5'd10, 1'b1, 1'b0, 8'd31},
    '{3'd3, 5'd12, 1'b1, 5'd16, 1'b1, 5'd12, 1'b1, 1'b0, 8'd32},
    '{3'd1, 5'd14, 1'b1, 5'd2,  1'b1, 5'd0,  1'b0, 1'b0, 8'd33},
    '{3'd4, 5'd14, 1'b1, 5'd10, 1'b1, 5'd14, 1'b1, 1'b0, 8'd38},
    '{3'd4, 5'd20, 1'b1, 5'd18, 1'b1, 5'd12, 1'b1, 1'b0, 8'd44},
    '{3'd0, 5'd1,  1'b1, 5'd1,  1'b1, 5'd0,  1'b0, 1'b0, 8'd45},
    '{3'd0, 5'd2,  1'b1, 5'd2,  1'b1, 5'd0,  1'b0, 1'b0, 8'd46},
    '{3'd6, 5'd0,  1'b0, 5'd14, 1'b1, 5'd2,  1'b1, 1'b0, 8'd47},
    '{3'd5, 5'd5,  1'b1, 5'd4,  1'b1, 5'd1,  1'b1, 1'b0, 8'd48},
    '{3'd7, 5'd0,  1'b0, 5'd5,  1'b1, 5'd0,  1'b0, 1'b1, 8'd50}
  };

  localparam int LATS [8] = '{0, 4, 12, 5, 1, 1, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_class;
  logic [4:0]  dst_reg;
  logic        dst_use;
  logic [4:0]  src_a;
  logic        src_a_use;
  logic [4:0]  src_b;
  logic        src_b_use;
  logic        br_taken;
  logic        issue_valid;
  logic        stall;
  logic [15:0] cycle_count;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  issue_interlock u_issue_interlock (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
    .dst_reg(dst_reg), .dst_use(dst_use), .src_a(src_a), .src_a_use(src_a_use),
    .src_b(src_b), .src_b_use(src_b_use), .br_taken(br_taken),
    .issue_valid(issue_valid), .stall(stall), .cycle_count(cycle_count)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [4:0] d, input logic du,
                       input logic [4:0] a, input logic au, input logic [4:0] b,
                       input logic bu, input logic tk);
    @(negedge clk);
    in_valid = 1'b1; op_class = op; dst_reg = d; dst_use = du;
    src_a = a; src_a_use = au; src_b = b; src_b_use = bu; br_taken = tk;
  endtask

  task automatic wait_issue(output int t);
    #1;
    while (!issue_valid) begin
      @(negedge clk);
      #1;
    end
    t = int'(cycle_count);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [4:0] d, input logic du,
                       input logic [4:0] a, input logic au, input logic [4:0] b,
                       input logic bu, input logic tk, output int t);
    drive(op, d, du, a, au, b, bu, tk);
    wait_issue(t);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base, t0, t1, t2;
    rst_n = 1'b0; in_valid = 1'b0; op_class = '0; dst_reg = '0; dst_use = 1'b0;
    src_a = '0; src_a_use = 1'b0; src_b = '0; src_b_use = 1'b0; br_taken = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 count in reset", int'(cycle_count), 0);
    chk("R1 stall in reset", int'(stall), 0);
    chk("R1 issue in reset", int'(issue_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 / R2 / R4 loop body table, two passes
    base = 0;
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].dst, TBL[i].du, TBL[i].sa, TBL[i].sau,
            TBL[i].sb, TBL[i].sbu, TBL[i].tk, t0);
      if (i == 0) base = t0;
      chk($sformatf("R9 loop entry %0d issue cycle", i), t0 - base, int'(TBL[i].exp_t));
    end

    // R5: register 0 as destination and source
    issue(3'd1, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t0);
    issue(3'd0, 5'd6, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, t1);
    chk("R5 r0 never pending", t1 - t0, 1);
    // R5: unused source fields ignored
    issue(3'd1, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t0);
    issue(3'd0, 5'd7, 1'b1, 5'd3, 1'b0, 5'd3, 1'b0, 1'b0, t1);
    chk("R5 unused fields", t1 - t0, 1);
    issue(3'd0, 5'd8, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0, 1'b0, t2);
    chk("R2 load wait with gap", t2 - t0, 5);

    // R2: each class, producer then consumer
    for (int k = 0; k < 8; k++) begin
      issue(3'(k), 5'(20 + k), 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t0);
      issue(3'd0, 5'd0, 1'b0, 5'(20 + k), 1'b1, 5'd0, 1'b0, 1'b0, t1);
      chk($sformatf("R2 class %0d latency", k), t1 - t0, LATS[k] + 1);
    end

    // R6: newest producer wins
    issue(3'd2, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t0);
    issue(3'd4, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t1);
    issue(3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd9, 1'b1, 1'b0, t2);
    chk("R6 newest producer", t2 - t1, 2);
    repeat (14) @(negedge clk);

    // R4 and R3: independent work during a divide, then held consumer
    issue(3'd2, 5'd11, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t0);
    issue(3'd0, 5'd12, 1'b1, 5'd12, 1'b1, 5'd0, 1'b0, 1'b0, t1);
    chk("R4 independent issue", t1 - t0, 1);
    drive(3'd0, 5'd0, 1'b0, 5'd11, 1'b1, 5'd0, 1'b0, 1'b0);
    #1;
    chk("R3 stall on hazard", int'(stall), 1);
    chk("R3 no issue on hazard", int'(issue_valid), 0);
    wait_issue(t2);
    chk("R2 divide consumer", t2 - t0, 13);

    // R7: taken branch slot
    issue(3'd7, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, t0);
    drive(3'd0, 5'd13, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    #1;
    chk("R7 slot stall", int'(stall), 1);
    chk("R7 slot no issue", int'(issue_valid), 0);
    wait_issue(t1);
    chk("R7 taken branch spacing", t1 - t0, 2);
    issue(3'd7, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t0);
    issue(3'd0, 5'd14, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t1);
    chk("R7 not-taken spacing", t1 - t0, 1);

    // R3 idle
    @(negedge clk);
    #1;
    chk("R3 idle stall", int'(stall), 0);
    chk("R3 idle issue", int'(issue_valid), 0);

    // R8 counter step
    t0 = int'(cycle_count);
    repeat (10) @(negedge clk);
    #1;
    chk("R8 counter over 10 cycles", int'(cycle_count) - t0, 10);

    // R1: reset mid-flight clears pending result
    issue(3'd2, 5'd15, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, t0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 count cleared", int'(cycle_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(3'd0, 5'd0, 1'b0, 5'd15, 1'b1, 5'd0, 1'b0, 1'b0);
    #1;
    chk("R1 pending cleared by reset", int'(issue_valid), 1);
    wait_issue(t1);

    finish_run();
  end

endmodule